// File: doc/BRIEF.md
# Host Command Interpreter with Entry Lock

This block sits behind a byte-wide host link and turns a stream of opcode and operand bytes into a decoded configuration register set for a display controller. A select input marks each byte as either an opcode or an operand. The opcode alone decides how many operand bytes follow: none, one, two, fifteen or sixty-four. The block counts and collects them, and once the last one arrives it raises a single-cycle update strobe that carries the opcode. The register file takes the update and refreshes the affected fields: the column and row windows, contrast, multiplex ratio, the two phase lengths, the display mode, the sleep state and a fifteen-entry gray-level pulse-width table.

A lock state guards command entry. While it is set, every byte is dropped except a complete unlock command, so a misbehaving host cannot change the configuration. The status byte reports whether the display is asleep.

Top module: `cmd_lock_interp`

## Requirements
- R1: Out of reset the block holds these values: multiplex ratio 127, phase-1 length 3, phase-2 length 5, contrast 0, all window fields 0, display mode 0, sleep 1, unlocked, and gray level k (1..15) equal to 4*k.
- R2: Opcodes 0x15 and 0x75 each take two operands. On completion the first operand sets the window start and the second sets the window end: 6 bits for columns, 7 bits for rows.
- R3: Opcodes 0x81, 0x82, 0x90, 0x91, 0x93-0x96, 0xA0-0xA2, 0xA8, 0xB1-0xB3, 0xBB, 0xBC, 0xBE and 0xFD each take one operand. 0x81 sets contrast to the full byte. 0xA8 sets the multiplex ratio to operand bits 6:0. 0xB1 sets phase-1 from bits 3:0 and phase-2 from bits 7:4. No other opcode changes contrast or the multiplex ratio.
- R4: Opcodes 0xA4-0xA7 take no operand and set the display mode to opcode bits 1:0. 0xAE sets sleep and 0xAF clears it. status_o bit 6 equals sleep and its other bits are 0.
- R5: Opcode 0x92 takes exactly 64 operands. Its update strobe appears only after the 64th operand.
- R6: Opcode 0xB8 takes 15 operands, and operand k writes gray level k from bits 5:0. The table changes only when the 15th operand completes the command. Opcode 0xB7 (no operand) restores level k to 4*k.
- R7: 0xFD followed by 0x13 sets the lock, and 0xFD followed by 0x12 clears it. While locked, every other command and operand is dropped, with no update strobe and no register change. An 0xFD with any other operand has no effect.
- R8: An opcode byte that arrives before the pending command has all its operands abandons that command. Operand bytes that arrive with no command pending are dropped.
- R9: An unknown opcode, and 0xE3, behave as a command with no operand. Each gives one update strobe and changes no register.
- R10: upd_vld_o goes high for one cycle, in the cycle after the byte that completes an accepted command, with upd_op_o holding that opcode. The register fields show the change one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Byte valid |
| cmd_i | input | 1 | 1: byte is an opcode, 0: operand |
| byte_i | input | 8 | Host byte |
| upd_vld_o | output | 1 | Command complete strobe |
| upd_op_o | output | 8 | Opcode of completed command |
| locked_o | output | 1 | Command entry locked |
| status_o | output | 8 | Status; bit 6 = display off |
| contrast_o | output | 8 | Contrast |
| mux_ratio_o | output | 7 | Multiplex ratio minus one |
| ph1_len_o | output | 4 | Phase-1 length field |
| ph2_len_o | output | 4 | Phase-2 length field |
| disp_mode_o | output | 2 | 0 normal, 1 all on, 2 all off, 3 inverse |
| sleep_o | output | 1 | Display asleep |
| col_start_o | output | 6 | Column window start |
| col_end_o | output | 6 | Column window end |
| row_start_o | output | 7 | Row window start |
| row_end_o | output | 7 | Row window end |
| gs_table_o | output | 90 | Gray levels 1..15, level k at bits [(k-1)*6 +: 6] |

## Verification
The bench builds the block with its default parameters: 64 icon operands, 15 gray levels of 6 bits, and the reset values listed above. These values exercise the full 64-operand count and the 15-operand table commit, including the case where the last table operand and the commit fall in the same cycle. Random command streams then mix truncated commands, stray operands, unknown opcodes and lock/unlock pairs. The bench compares every register field with its own model.

// File: rtl/cli_pkg.sv
package cli_pkg;
  localparam logic [7:0] OP_COLWIN   = 8'h15;
  localparam logic [7:0] OP_ROWWIN   = 8'h75;
  localparam logic [7:0] OP_CONTRAST = 8'h81;
  localparam logic [7:0] OP_ICONCUR  = 8'h92;
  localparam logic [7:0] OP_MUX      = 8'hA8;
  localparam logic [7:0] OP_SLEEP    = 8'hAE;
  localparam logic [7:0] OP_WAKE     = 8'hAF;
  localparam logic [7:0] OP_PHASE    = 8'hB1;
  localparam logic [7:0] OP_GSDEF    = 8'hB7;
  localparam logic [7:0] OP_GSTAB    = 8'hB8;
  localparam logic [7:0] OP_LOCK     = 8'hFD;
  localparam logic [7:0] KEY_UNLOCK  = 8'h12;
  localparam logic [7:0] KEY_LOCK    = 8'h13;

  function automatic logic [7:0] gs_default(int unsigned level);
    return 8'(4 * level);
  endfunction
endpackage

// File: rtl/cli_len_dec.sv
module cli_len_dec #(
  parameter int unsigned ICON_N    = 64,
  parameter int unsigned GS_LEVELS = 15,
  parameter int unsigned CNT_W     = 7
) (
  input  logic [7:0]       op_i,
  output logic [CNT_W-1:0] len_o
);
  always_comb begin
    unique case (op_i)
      8'h15, 8'h75: len_o = CNT_W'(2);
      8'h92:        len_o = CNT_W'(ICON_N);
      8'hB8:        len_o = CNT_W'(GS_LEVELS);
      8'h81, 8'h82, 8'h90, 8'h91, 8'h93, 8'h94, 8'h95, 8'h96,
      8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hB1, 8'hB2, 8'hB3,
      8'hBB, 8'hBC, 8'hBE, 8'hFD: len_o = CNT_W'(1);
      default:      len_o = '0;
    endcase
  end
endmodule

// File: rtl/cli_collect.sv
module cli_collect
  import cli_pkg::*;
#(
  parameter int unsigned ICON_N    = 64,
  parameter int unsigned GS_LEVELS = 15,
  parameter int unsigned CNT_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             cmd_i,
  input  logic [7:0]       byte_i,
  output logic             upd_vld_o,
  output logic [7:0]       upd_op_o,
  output logic [7:0]       upd_p0_o,
  output logic [7:0]       upd_p1_o,
  output logic             par_vld_o,
  output logic [7:0]       par_op_o,
  output logic [CNT_W-1:0] par_idx_o,
  output logic [7:0]       par_byte_o,
  output logic             locked_o
);
  logic [CNT_W-1:0] len;
  logic             busy_q, lock_q;
  logic [7:0]       op_q, p0_q, p1_q;
  logic [CNT_W-1:0] need_q, idx_q;

  cli_len_dec #(.ICON_N(ICON_N), .GS_LEVELS(GS_LEVELS), .CNT_W(CNT_W)) u_len (
    .op_i (byte_i),
    .len_o(len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      lock_q     <= 1'b0;
      op_q       <= '0;
      p0_q       <= '0;
      p1_q       <= '0;
      need_q     <= '0;
      idx_q      <= '0;
      upd_vld_o  <= 1'b0;
      upd_op_o   <= '0;
      upd_p0_o   <= '0;
      upd_p1_o   <= '0;
      par_vld_o  <= 1'b0;
      par_op_o   <= '0;
      par_idx_o  <= '0;
      par_byte_o <= '0;
    end else begin
      upd_vld_o <= 1'b0;
      par_vld_o <= 1'b0;
      if (vld_i && cmd_i) begin
        // a new opcode always drops any partial command
        if (lock_q && byte_i != OP_LOCK) begin
          busy_q <= 1'b0;
        end else if (len == '0) begin
          busy_q    <= 1'b0;
          upd_vld_o <= 1'b1;
          upd_op_o  <= byte_i;
        end else begin
          busy_q <= 1'b1;
          op_q   <= byte_i;
          need_q <= len;
          idx_q  <= '0;
        end
      end else if (vld_i && busy_q) begin
        par_vld_o  <= 1'b1;
        par_op_o   <= op_q;
        par_idx_o  <= idx_q;
        par_byte_o <= byte_i;
        idx_q      <= idx_q + 1'b1;
        need_q     <= need_q - 1'b1;
        if (idx_q == CNT_W'(0)) p0_q <= byte_i;
        if (idx_q == CNT_W'(1)) p1_q <= byte_i;
        if (need_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          if (op_q == OP_LOCK) begin
            if (byte_i == KEY_UNLOCK) begin
              lock_q    <= 1'b0;
              upd_vld_o <= 1'b1;
              upd_op_o  <= op_q;
              upd_p0_o  <= byte_i;
            end else if (byte_i == KEY_LOCK && !lock_q) begin
              lock_q    <= 1'b1;
              upd_vld_o <= 1'b1;
              upd_op_o  <= op_q;
              upd_p0_o  <= byte_i;
            end
          end else begin
            upd_vld_o <= 1'b1;
            upd_op_o  <= op_q;
            upd_p0_o  <= (idx_q == CNT_W'(0)) ? byte_i : p0_q;
            upd_p1_o  <= (idx_q == CNT_W'(1)) ? byte_i : p1_q;
          end
        end
      end
    end
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/cli_regs.sv
module cli_regs
  import cli_pkg::*;
#(
  parameter int unsigned GS_LEVELS    = 15,
  parameter int unsigned GS_W         = 6,
  parameter int unsigned CNT_W        = 7,
  parameter int unsigned MUX_RST      = 127,
  parameter int unsigned PH1_RST      = 3,
  parameter int unsigned PH2_RST      = 5,
  parameter int unsigned CONTRAST_RST = 0,
  localparam int unsigned GS_BITS     = GS_LEVELS * GS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_vld_i,
  input  logic [7:0]         upd_op_i,
  input  logic [7:0]         upd_p0_i,
  input  logic [7:0]         upd_p1_i,
  input  logic               par_vld_i,
  input  logic [7:0]         par_op_i,
  input  logic [CNT_W-1:0]   par_idx_i,
  input  logic [7:0]         par_byte_i,
  output logic [7:0]         contrast_o,
  output logic [6:0]         mux_ratio_o,
  output logic [3:0]         ph1_len_o,
  output logic [3:0]         ph2_len_o,
  output logic [1:0]         disp_mode_o,
  output logic               sleep_o,
  output logic [5:0]         col_start_o,
  output logic [5:0]         col_end_o,
  output logic [6:0]         row_start_o,
  output logic [6:0]         row_end_o,
  output logic [GS_BITS-1:0] gs_table_o
);
  logic unused_ok;
  assign unused_ok = ^{upd_p1_i[7], par_byte_i[7:GS_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      contrast_o  <= 8'(CONTRAST_RST);
      mux_ratio_o <= 7'(MUX_RST);
      ph1_len_o   <= 4'(PH1_RST);
      ph2_len_o   <= 4'(PH2_RST);
      disp_mode_o <= 2'd0;
      sleep_o     <= 1'b1;
      col_start_o <= '0;
      col_end_o   <= '0;
      row_start_o <= '0;
      row_end_o   <= '0;
    end else if (upd_vld_i) begin
      case (upd_op_i)
        OP_COLWIN:   begin col_start_o <= upd_p0_i[5:0]; col_end_o <= upd_p1_i[5:0]; end
        OP_ROWWIN:   begin row_start_o <= upd_p0_i[6:0]; row_end_o <= upd_p1_i[6:0]; end
        OP_CONTRAST: contrast_o <= upd_p0_i;
        OP_MUX:      mux_ratio_o <= upd_p0_i[6:0];
        OP_PHASE:    begin ph1_len_o <= upd_p0_i[3:0]; ph2_len_o <= upd_p0_i[7:4]; end
        8'hA4, 8'hA5, 8'hA6, 8'hA7: disp_mode_o <= upd_op_i[1:0];
        OP_SLEEP:    sleep_o <= 1'b1;
        OP_WAKE:     sleep_o <= 1'b0;
        default: ;
      endcase
    end
  end

  // staged entries commit together when the table command completes
  for (genvar g = 0; g < GS_LEVELS; g++) begin : g_gs
    logic [GS_W-1:0] stage_q, tab_q;
    logic            wr;
    assign wr = par_vld_i && par_op_i == OP_GSTAB && par_idx_i == CNT_W'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        tab_q   <= GS_W'(gs_default(g + 1));
      end else begin
        if (wr) stage_q <= par_byte_i[GS_W-1:0];
        if (upd_vld_i && upd_op_i == OP_GSDEF) tab_q <= GS_W'(gs_default(g + 1));
        else if (upd_vld_i && upd_op_i == OP_GSTAB)
          tab_q <= wr ? par_byte_i[GS_W-1:0] : stage_q;
      end
    end
    assign gs_table_o[g*GS_W +: GS_W] = tab_q;
  end
endmodule

// File: rtl/cmd_lock_interp.sv
module cmd_lock_interp #(
  parameter int unsigned ICON_N       = 64,
  parameter int unsigned GS_LEVELS    = 15,
  parameter int unsigned GS_W         = 6,
  parameter int unsigned MUX_RST      = 127,
  parameter int unsigned PH1_RST      = 3,
  parameter int unsigned PH2_RST      = 5,
  parameter int unsigned CONTRAST_RST = 0,
  localparam int unsigned CNT_W       = $clog2(ICON_N + 1),
  localparam int unsigned GS_BITS     = GS_LEVELS * GS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic               cmd_i,
  input  logic [7:0]         byte_i,
  output logic               upd_vld_o,
  output logic [7:0]         upd_op_o,
  output logic               locked_o,
  output logic [7:0]         status_o,
  output logic [7:0]         contrast_o,
  output logic [6:0]         mux_ratio_o,
  output logic [3:0]         ph1_len_o,
  output logic [3:0]         ph2_len_o,
  output logic [1:0]         disp_mode_o,
  output logic               sleep_o,
  output logic [5:0]         col_start_o,
  output logic [5:0]         col_end_o,
  output logic [6:0]         row_start_o,
  output logic [6:0]         row_end_o,
  output logic [GS_BITS-1:0] gs_table_o
);
  logic [7:0]       upd_p0, upd_p1, par_op, par_byte;
  logic             par_vld;
  logic [CNT_W-1:0] par_idx;

  cli_collect #(.ICON_N(ICON_N), .GS_LEVELS(GS_LEVELS), .CNT_W(CNT_W)) u_collect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (vld_i),
    .cmd_i     (cmd_i),
    .byte_i    (byte_i),
    .upd_vld_o (upd_vld_o),
    .upd_op_o  (upd_op_o),
    .upd_p0_o  (upd_p0),
    .upd_p1_o  (upd_p1),
    .par_vld_o (par_vld),
    .par_op_o  (par_op),
    .par_idx_o (par_idx),
    .par_byte_o(par_byte),
    .locked_o  (locked_o)
  );

  cli_regs #(
    .GS_LEVELS(GS_LEVELS), .GS_W(GS_W), .CNT_W(CNT_W), .MUX_RST(MUX_RST),
    .PH1_RST(PH1_RST), .PH2_RST(PH2_RST), .CONTRAST_RST(CONTRAST_RST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_vld_i  (upd_vld_o),
    .upd_op_i   (upd_op_o),
    .upd_p0_i   (upd_p0),
    .upd_p1_i   (upd_p1),
    .par_vld_i  (par_vld),
    .par_op_i   (par_op),
    .par_idx_i  (par_idx),
    .par_byte_i (par_byte),
    .contrast_o (contrast_o),
    .mux_ratio_o(mux_ratio_o),
    .ph1_len_o  (ph1_len_o),
    .ph2_len_o  (ph2_len_o),
    .disp_mode_o(disp_mode_o),
    .sleep_o    (sleep_o),
    .col_start_o(col_start_o),
    .col_end_o  (col_end_o),
    .row_start_o(row_start_o),
    .row_end_o  (row_end_o),
    .gs_table_o (gs_table_o)
  );

  assign status_o = {1'b0, sleep_o, 6'b0};
endmodule

// File: rtl/cmd_lock_interp_chk.sv
module cmd_lock_interp_chk #(
  parameter int unsigned GS_BITS = 90
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               vld_i,
  input logic               cmd_i,
  input logic [7:0]         byte_i,
  input logic               upd_vld_o,
  input logic [7:0]         upd_op_o,
  input logic               locked_o,
  input logic [7:0]         contrast_o,
  input logic [6:0]         mux_ratio_o,
  input logic [1:0]         disp_mode_o,
  input logic               sleep_o,
  input logic [GS_BITS-1:0] gs_table_o
);
  p_sleep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_vld_o && upd_op_o == 8'hAE |=> sleep_o);

  p_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_vld_o && upd_op_o[7:2] == 6'b101001 |=> disp_mode_o == $past(upd_op_o[1:0]));

  p_contrast_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_vld_o && upd_op_o == 8'h81) |=> $stable(contrast_o));

  p_mux_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_vld_o && upd_op_o == 8'hA8) |=> $stable(mux_ratio_o));

  p_locked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o && upd_vld_o |-> upd_op_o == 8'hFD);

  p_unlock_key_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(vld_i && !cmd_i && byte_i == 8'h12));

  p_gs_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_vld_o && (upd_op_o == 8'hB8 || upd_op_o == 8'hB7)) |=> $stable(gs_table_o));

  p_upd_follows_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_vld_o |-> $past(vld_i));
endmodule

bind cmd_lock_interp cmd_lock_interp_chk #(.GS_BITS(GS_BITS)) u_chk (.*);

// File: tb/sim_cmd_lock_interp.sv
module sim_cmd_lock_interp;
  localparam int GSL = 15;

  logic        clk_i = 1'b0, rst_ni = 1'b0, vld_i = 1'b0, cmd_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        upd_vld_o, locked_o, sleep_o;
  logic [7:0]  upd_op_o, status_o, contrast_o;
  logic [6:0]  mux_ratio_o, row_start_o, row_end_o;
  logic [3:0]  ph1_len_o, ph2_len_o;
  logic [1:0]  disp_mode_o;
  logic [5:0]  col_start_o, col_end_o;
  logic [89:0] gs_table_o;

  cmd_lock_interp u0 (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int obs_upd = 0, exp_upd = 0;
  logic [7:0] obs_op;

  always @(negedge clk_i) if (rst_ni && upd_vld_o) begin obs_upd++; obs_op = upd_op_o; end

  // reference model
  bit m_busy, m_lock;
  logic [7:0] m_op, m_p0, m_p1;
  int m_need, m_idx;
  logic [7:0] e_con, e_status;
  logic [6:0] e_mux, e_rs, e_re;
  logic [3:0] e_ph1, e_ph2;
  logic [1:0] e_mode;
  logic       e_sleep;
  logic [5:0] e_cs, e_ce;
  logic [5:0] e_gs [GSL], e_stage [GSL];

  function automatic int plen(logic [7:0] op);
    if (op == 8'h15 || op == 8'h75) return 2;
    if (op == 8'h92) return 64;
    if (op == 8'hB8) return 15;
    if (op inside {8'h81, 8'h82, 8'h90, 8'h91, [8'h93:8'h96], [8'hA0:8'hA2], 8'hA8,
                   [8'hB1:8'hB3], 8'hBB, 8'hBC, 8'hBE, 8'hFD}) return 1;
    return 0;
  endfunction

  function automatic logic [89:0] gs_pack();
    logic [89:0] v;
    for (int k = 0; k < GSL; k++) v[k*6 +: 6] = e_gs[k];
    return v;
  endfunction

  task automatic model_reset();
    m_busy = 0; m_lock = 0;
    e_con = 0; e_mux = 127; e_ph1 = 3; e_ph2 = 5; e_mode = 0; e_sleep = 1;
    e_cs = 0; e_ce = 0; e_rs = 0; e_re = 0;
    for (int k = 0; k < GSL; k++) begin e_gs[k] = 6'((k + 1) * 4); e_stage[k] = 0; end
  endtask

  task automatic complete(logic [7:0] op, logic [7:0] a, logic [7:0] b);
    exp_upd++;
    case (op)
      8'h15: begin e_cs = a[5:0]; e_ce = b[5:0]; end
      8'h75: begin e_rs = a[6:0]; e_re = b[6:0]; end
      8'h81: e_con = a;
      8'hA8: e_mux = a[6:0];
      8'hB1: begin e_ph1 = a[3:0]; e_ph2 = a[7:4]; end
      8'hA4, 8'hA5, 8'hA6, 8'hA7: e_mode = op[1:0];
      8'hAE: e_sleep = 1;
      8'hAF: e_sleep = 0;
      8'hB7: for (int k = 0; k < GSL; k++) e_gs[k] = 6'((k + 1) * 4);
      8'hB8: for (int k = 0; k < GSL; k++) e_gs[k] = e_stage[k];
      default: ;
    endcase
  endtask

  task automatic model_byte(bit c, logic [7:0] b);
    if (c) begin
      if (m_lock && b != 8'hFD) m_busy = 0;
      else if (plen(b) == 0) begin m_busy = 0; complete(b, 0, 0); end
      else begin m_busy = 1; m_op = b; m_need = plen(b); m_idx = 0; end
    end else if (m_busy) begin
      if (m_op == 8'hB8) e_stage[m_idx] = b[5:0];
      if (m_idx == 0) m_p0 = b;
      if (m_idx == 1) m_p1 = b;
      m_idx++; m_need--;
      if (m_need == 0) begin
        m_busy = 0;
        if (m_op == 8'hFD) begin
          if (b == 8'h12) begin m_lock = 0; exp_upd++; end
          else if (b == 8'h13 && !m_lock) begin m_lock = 1; exp_upd++; end
        end else complete(m_op, m_p0, m_p1);
      end
    end
  endtask

  task automatic send(bit c, logic [7:0] b);
    vld_i = 1; cmd_i = c; byte_i = b;
    model_byte(c, b);
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    vld_i = 0; cmd_i = 0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " R3 contrast"}, contrast_o, e_con);
    chk({tag, " R3 mux"}, mux_ratio_o, e_mux);
    chk({tag, " R3 phases"}, {ph1_len_o, ph2_len_o}, {e_ph1, e_ph2});
    chk({tag, " R4 mode/sleep"}, {disp_mode_o, sleep_o}, {e_mode, e_sleep});
    chk({tag, " R4 status"}, status_o, {1'b0, e_sleep, 6'b0});
    chk({tag, " R2 windows"}, {col_start_o, col_end_o, row_start_o, row_end_o},
        {e_cs, e_ce, e_rs, e_re});
    chk({tag, " R6 gs"}, gs_table_o, gs_pack());
    chk({tag, " R7 lock"}, locked_o, m_lock);
    chk({tag, " R10 upd count"}, obs_upd, exp_upd);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pool [22];
    void'($urandom(32'h5eed1));
    pool = '{8'h15, 8'h75, 8'h81, 8'hA8, 8'hB1, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAE,
             8'hAF, 8'hB7, 8'hB8, 8'h92, 8'hE3, 8'h3C, 8'hFD, 8'h82, 8'hA0, 8'hBE,
             8'hFD, 8'h81};
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk_all("R1 reset");

    // R5: icon currents complete only on the 64th operand
    send(1, 8'h92);
    for (int i = 0; i < 63; i++) send(0, 8'(i));
    idle(3);
    chk("R5 no strobe before 64th", obs_upd, exp_upd);
    chk("R5 count before", obs_upd, 0);
    send(0, 8'h40); idle(2);
    chk("R5 strobe after 64th", obs_upd, 1);
    chk("R10 opcode 92", obs_op, 8'h92);

    // R6: table commits only at the 15th operand
    send(1, 8'hB8);
    for (int i = 0; i < 14; i++) send(0, 8'hC0 | 8'(i + 20));
    idle(3);
    chk_all("R6 partial");
    send(0, 8'hFF); idle(2);
    chk_all("R6 commit");
    chk("R6 level15", gs_table_o[89:84], 6'h3F);
    send(1, 8'hB7); idle(2);
    chk_all("R6 default");

    // R8: abandon and stray operand
    send(1, 8'h81); send(1, 8'hA5); send(0, 8'h55); idle(2);
    chk("R8 contrast kept", contrast_o, 8'h00);
    chk("R8 mode", disp_mode_o, 2'd1);

    // R9: unknown opcode and no-op
    send(1, 8'h3C); send(1, 8'hE3); idle(2);
    chk("R9 opcode", obs_op, 8'hE3);
    chk_all("R9");

    // R7: lock blocks, unlock restores
    send(1, 8'hFD); send(0, 8'h13); idle(2);
    chk("R7 locked", locked_o, 1'b1);
    send(1, 8'h81); send(0, 8'h77); send(1, 8'hAF); send(1, 8'hFD); send(0, 8'h55);
    idle(2);
    chk_all("R7 while locked");
    send(1, 8'hFD); send(0, 8'h12); idle(2);
    chk("R7 unlocked", locked_o, 1'b0);
    send(1, 8'h81); send(0, 8'h9A); idle(2);
    chk("R3 contrast after unlock", contrast_o, 8'h9A);

    // random streams
    for (int it = 0; it < 400; it++) begin
      logic [7:0] op;
      int n, r;
      op = pool[$urandom_range(0, 21)];
      n = plen(op);
      r = $urandom_range(0, 9);
      if (r == 0 && n > 0) n = $urandom_range(0, n - 1);
      if ($urandom_range(0, 15) == 0) send(0, 8'($urandom));
      send(1, op);
      for (int i = 0; i < n; i++) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (op == 8'hFD) d = ($urandom_range(0, 3) == 0) ? d : 8'h12 | 8'($urandom_range(0, 1));
        send(0, d);
      end
      if ($urandom_range(0, 1) == 0) idle(1);
      if (it % 8 == 7) begin idle(2); chk_all("rand R2 R3 R4 R7 R8"); end
    end
    idle(2);
    chk_all("final");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule